// File: doc/BRIEF.md
# Root Clock Configuration Update Controller

This block holds the settings for one root clock generator in two copies. Software writes a staged copy through a small register port. The staged copy covers the source select, the pre-divider, the counter mode and the M, N and D values. The staged values do not drive anything. The clock path sees only the active copy. Software moves the staged copy into the active copy by setting a request bit in the command word.

The controller waits for a point where the switch is safe. That point is a strobe from the clock path. When the root clock is off, no glitch is possible, so the controller applies the change on the next edge instead. In the same edge it copies every field and clears the request bit. Four dirty flags show which staged registers hold changes that are not yet applied. A status bit reports whether the root clock is off. The root is on when the software enable bit is set or the hardware enable input is high.

The sequencing is a two-state machine:

| State | Meaning |
|---|---|
| `ST_IDLE` | No request is pending. |
| `ST_ARMED` | A request is waiting for its safe point. |

| Transition | Condition |
|---|---|
| ARM | A command write with the request bit set moves `ST_IDLE` to `ST_ARMED`. |
| COMMIT | In `ST_ARMED`, the strobe or an off root applies the staged copy and returns to `ST_IDLE`. |
| RE-ARM | A new request written in the commit cycle keeps the machine in `ST_ARMED`. |
| HOLD | Anything else stays in `ST_ARMED`. |

Top module: `rcg_update_ctrl`

## Requirements
- R1: After reset, the following are all zero: every active output, every staged value, the pending request, the dirty flags and the software root enable.
- R2: Registers sit at these byte addresses: command 0x00, config 0x04, M 0x08, N 0x0C, D 0x10.
  - Config holds the pre-divider in bits 4:0, the source select in bits 10:8 and the counter mode in bits 13:12. Its other bits read as 0.
  - M, N and D use the low MND_W bits.
  - Any other address reads 0, and a write to it changes nothing.
- R3: Writing a staged register leaves every active output unchanged until an update is applied.
- R4: Writing 1 to command bit 0 sets the pending request. Pending reads back in bit 0.
  - With the root on, the staged copy is applied at the first clock edge where `safe_sw` is high.
  - Pending clears at that same edge.
- R5: With the root off, a pending request is applied, and cleared, at the first clock edge after the request was written. No strobe is needed.
- R6: Command bits 7:4 are dirty flags: bit 4 for config, bit 5 for M, bit 6 for N, bit 7 for D. A write sets its flag only if it changes the staged value.
- R7: Applying an update clears all dirty flags. A staged write made while a request is pending is carried by that same update.
- R8: Writing 0 to command bit 0 while a request is pending does not cancel the request.
- R9: Command bit 1 is the software root enable. Command bit 31 and `root_off` read 1 exactly when both command bit 1 and `hw_root_en` are 0.
- R10: `act_mnd_on` is 1 exactly when the active counter mode is 2 (dual-edge M/N:D). Mode 0 is bypass.
- R11: A staged write in the same cycle as a commit behaves as follows:
  - The commit uses the value staged before that write.
  - The new value stays staged.
  - Its dirty flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 5 | Byte address of the write |
| wr_data | input | 32 | Write data |
| rd_addr | input | 5 | Byte address of the read |
| rd_data | output | 32 | Read data, combinational from `rd_addr` |
| hw_root_en | input | 1 | Hardware request to keep the root running |
| safe_sw | input | 1 | Safe-to-switch strobe from the clock path |
| act_src | output | 3 | Active source select |
| act_div | output | 5 | Active pre-divider |
| act_mode | output | 2 | Active counter mode |
| act_mnd_on | output | 1 | Dual-edge counter in use |
| act_m | output | MND_W | Active M value |
| act_n | output | MND_W | Active N value |
| act_d | output | MND_W | Active D value |
| upd_pending | output | 1 | Update request outstanding |
| root_off | output | 1 | Root clock is off |

## Verification
The commit is tried in three ways:
- With the root off, where no strobe should be needed. This separates the off-root shortcut from the strobe path.
- With the root on, first holding the strobe low for several cycles and then pulsing it. This shows that the strobe alone releases the commit.
- With a staged write landing in the same cycle as the strobe. This shows which copy a racing write reaches.

Three further patterns check the dirty flags and the request bit:
- Rewriting a value that is already staged, which must not set a dirty flag.
- Writing a new value while a request is pending, which must be merged into that request.
- Writing a command word with bit 0 clear, which must leave the pending request in place.

// File: rtl/rcg_pkg.sv
package rcg_pkg;

    localparam int ADDR_W = 5;

    localparam logic [ADDR_W-1:0] OFF_CMD  = 5'h00;
    localparam logic [ADDR_W-1:0] OFF_CFG  = 5'h04;
    localparam int                OFF_MND0 = 8;
    localparam int                NUM_MND  = 3;

    localparam logic [1:0] MODE_DUAL_EDGE = 2'd2;

    typedef enum logic [0:0] {
        ST_IDLE  = 1'b0,
        ST_ARMED = 1'b1
    } upd_state_e;

    typedef struct packed {
        logic [2:0] src;
        logic [4:0] div;
        logic [1:0] mode;
    } root_cfg_t;

endpackage

// File: rtl/rcg_stage_bank.sv
module rcg_stage_bank
    import rcg_pkg::*;
#(
    parameter int MND_W = 16
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           wr_en,
    input  logic [ADDR_W-1:0]              wr_addr,
    input  logic [31:0]                    wr_data,
    input  logic                           apply,
    output root_cfg_t                      stg_cfg,
    output logic [NUM_MND-1:0][MND_W-1:0]  stg_mnd,
    output logic [NUM_MND:0]               dirty
);

    root_cfg_t          cfg_wval;
    logic               cfg_chg;
    logic [NUM_MND-1:0] mnd_chg;
    logic [NUM_MND:0]   chg_vec;
    logic               unused_wbits;

    assign cfg_wval.src  = wr_data[10:8];
    assign cfg_wval.div  = wr_data[4:0];
    assign cfg_wval.mode = wr_data[13:12];
    assign unused_wbits  = ^{wr_data[31:14], wr_data[11], wr_data[7:5]};

    assign cfg_chg = wr_en && (wr_addr == OFF_CFG) && (cfg_wval != stg_cfg);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stg_cfg <= '0;
        end else if (wr_en && (wr_addr == OFF_CFG)) begin
            stg_cfg <= cfg_wval;
        end
    end

    for (genvar i = 0; i < NUM_MND; i++) begin : g_mnd
        localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(OFF_MND0 + 4 * i);
        logic hit;

        assign hit        = wr_en && (wr_addr == MY_ADDR);
        assign mnd_chg[i] = hit && (wr_data[MND_W-1:0] != stg_mnd[i]);

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                stg_mnd[i] <= '0;
            end else if (hit) begin
                stg_mnd[i] <= wr_data[MND_W-1:0];
            end
        end
    end

    assign chg_vec = {mnd_chg, cfg_chg};

    // A change written in the commit cycle stays flagged.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dirty <= '0;
        end else if (apply) begin
            dirty <= chg_vec;
        end else begin
            dirty <= dirty | chg_vec;
        end
    end

    // R7
    dirty_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (apply && !wr_en) |=> (dirty == '0));

endmodule

// File: rtl/rcg_update_fsm.sv
module rcg_update_fsm
    import rcg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_set,
    input  logic root_on,
    input  logic safe_sw,
    output logic pending,
    output logic apply
);

    upd_state_e state_q;
    upd_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (req_set) begin
                    state_d = ST_ARMED;
                end
            end
            ST_ARMED: begin
                if ((safe_sw || !root_on) && !req_set) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        pending = 1'b0;
        apply   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                pending = 1'b0;
                apply   = 1'b0;
            end
            ST_ARMED: begin
                pending = 1'b1;
                apply   = safe_sw || !root_on;
            end
            default: begin
                pending = 1'b0;
                apply   = 1'b0;
            end
        endcase
    end

    // R4
    safe_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pending && root_on && safe_sw && !req_set) |=> !pending);

    // R5
    off_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pending && !root_on && !req_set) |=> !pending);

    // R8
    hold_armed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pending && root_on && !safe_sw) |=> pending);

endmodule

// File: rtl/rcg_active_bank.sv
module rcg_active_bank
    import rcg_pkg::*;
#(
    parameter int MND_W = 16
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           apply,
    input  root_cfg_t                      stg_cfg,
    input  logic [NUM_MND-1:0][MND_W-1:0]  stg_mnd,
    output root_cfg_t                      act_cfg,
    output logic [NUM_MND-1:0][MND_W-1:0]  act_mnd,
    output logic                           mnd_on
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act_cfg <= '0;
            act_mnd <= '0;
        end else if (apply) begin
            act_cfg <= stg_cfg;
            act_mnd <= stg_mnd;
        end
    end

    assign mnd_on = (act_cfg.mode == MODE_DUAL_EDGE);

    // R3
    active_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !apply |=> ($stable(act_cfg) && $stable(act_mnd)));

endmodule

// File: rtl/rcg_update_ctrl.sv
module rcg_update_ctrl
    import rcg_pkg::*;
#(
    parameter int MND_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [4:0]        wr_addr,
    input  logic [31:0]       wr_data,
    input  logic [4:0]        rd_addr,
    output logic [31:0]       rd_data,
    input  logic              hw_root_en,
    input  logic              safe_sw,
    output logic [2:0]        act_src,
    output logic [4:0]        act_div,
    output logic [1:0]        act_mode,
    output logic              act_mnd_on,
    output logic [MND_W-1:0]  act_m,
    output logic [MND_W-1:0]  act_n,
    output logic [MND_W-1:0]  act_d,
    output logic              upd_pending,
    output logic              root_off
);

    root_cfg_t                      stg_cfg;
    root_cfg_t                      act_cfg;
    logic [NUM_MND-1:0][MND_W-1:0]  stg_mnd;
    logic [NUM_MND-1:0][MND_W-1:0]  act_mnd;
    logic [NUM_MND:0]               dirty;
    logic                           sw_root_en;
    logic                           root_on;
    logic                           cmd_wr;
    logic                           req_set;
    logic                           apply;

    assign cmd_wr  = wr_en && (wr_addr == OFF_CMD);
    assign req_set = cmd_wr && wr_data[0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sw_root_en <= 1'b0;
        end else if (cmd_wr) begin
            sw_root_en <= wr_data[1];
        end
    end

    assign root_on  = sw_root_en || hw_root_en;
    assign root_off = !root_on;

    rcg_stage_bank #(.MND_W(MND_W)) u_stage (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .apply   (apply),
        .stg_cfg (stg_cfg),
        .stg_mnd (stg_mnd),
        .dirty   (dirty)
    );

    rcg_update_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .req_set (req_set),
        .root_on (root_on),
        .safe_sw (safe_sw),
        .pending (upd_pending),
        .apply   (apply)
    );

    rcg_active_bank #(.MND_W(MND_W)) u_active (
        .clk     (clk),
        .rst_n   (rst_n),
        .apply   (apply),
        .stg_cfg (stg_cfg),
        .stg_mnd (stg_mnd),
        .act_cfg (act_cfg),
        .act_mnd (act_mnd),
        .mnd_on  (act_mnd_on)
    );

    assign act_src  = act_cfg.src;
    assign act_div  = act_cfg.div;
    assign act_mode = act_cfg.mode;
    assign act_m    = act_mnd[0];
    assign act_n    = act_mnd[1];
    assign act_d    = act_mnd[2];

    always_comb begin
        rd_data = '0;
        if (rd_addr == OFF_CMD) begin
            rd_data[0]   = upd_pending;
            rd_data[1]   = sw_root_en;
            rd_data[7:4] = dirty;
            rd_data[31]  = root_off;
        end else if (rd_addr == OFF_CFG) begin
            rd_data[4:0]   = stg_cfg.div;
            rd_data[10:8]  = stg_cfg.src;
            rd_data[13:12] = stg_cfg.mode;
        end
        for (int i = 0; i < NUM_MND; i++) begin
            if (rd_addr == 5'(OFF_MND0 + 4 * i)) begin
                rd_data[MND_W-1:0] = stg_mnd[i];
            end
        end
    end

endmodule

// File: tb/rcg_update_ctrl_tb.sv
module rcg_update_ctrl_tb;

    localparam int CLK_PERIOD = 10;
    localparam int MND_W      = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_en = 1'b0;
    logic [4:0]        wr_addr = '0;
    logic [31:0]       wr_data = '0;
    logic [4:0]        rd_addr = '0;
    logic [31:0]       rd_data;
    logic              hw_root_en = 1'b0;
    logic              safe_sw = 1'b0;
    logic [2:0]        act_src;
    logic [4:0]        act_div;
    logic [1:0]        act_mode;
    logic              act_mnd_on;
    logic [MND_W-1:0]  act_m, act_n, act_d;
    logic              upd_pending;
    logic              root_off;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    rcg_update_ctrl #(.MND_W(MND_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .hw_root_en(hw_root_en), .safe_sw(safe_sw),
        .act_src(act_src), .act_div(act_div), .act_mode(act_mode), .act_mnd_on(act_mnd_on),
        .act_m(act_m), .act_n(act_n), .act_d(act_d), .upd_pending(upd_pending),
        .root_off(root_off)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic reg_wr(input logic [4:0] a, input logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic reg_rd(input logic [4:0] a, output logic [31:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    function automatic logic [31:0] act_word();
        return {act_d, act_n[7:0], act_m[7:0]};
    endfunction

    task automatic t_reset();
        logic [31:0] v;
        reg_rd(5'h00, v);
        check("R1 R9 cmd after reset", v, 32'h8000_0000);
        reg_rd(5'h08, v);
        check("R1 staged M after reset", v, 32'h0);
        check("R1 active cfg after reset", {act_src, act_div, act_mode, act_mnd_on}, 32'h0);
        check("R1 active mnd after reset", act_word(), 32'h0);
        check("R9 root_off pin after reset", root_off, 1'b1);
    endtask

    task automatic t_map();
        logic [31:0] v;
        reg_wr(5'h04, 32'hF00F_21E7);
        reg_wr(5'h08, 32'h0000_0003);
        reg_wr(5'h0C, 32'h0000_FFF8);
        reg_wr(5'h10, 32'h0000_FFF9);
        reg_rd(5'h04, v);
        check("R2 config readback", v, 32'h0000_2107);
        reg_rd(5'h0C, v);
        check("R2 N readback", v, 32'h0000_FFF8);
        reg_rd(5'h10, v);
        check("R2 D readback", v, 32'h0000_FFF9);
        reg_rd(5'h00, v);
        check("R6 all dirty set", v, 32'h8000_00F0);
        check("R3 active cfg unchanged", {act_src, act_div, act_mode}, 32'h0);
        check("R3 active mnd unchanged", act_word(), 32'h0);
        reg_wr(5'h14, 32'hFFFF_FFFF);
        reg_rd(5'h14, v);
        check("R2 unmapped reads zero", v, 32'h0);
        reg_rd(5'h00, v);
        check("R2 unmapped write no effect", v, 32'h8000_00F0);
    endtask

    task automatic t_root_off_apply();
        logic [31:0] v;
        reg_wr(5'h00, 32'h0000_0001);
        reg_rd(5'h00, v);
        check("R5 pending before edge", v, 32'h8000_00F1);
        check("R5 active held before edge", act_src, 3'd0);
        @(negedge clk);
        reg_rd(5'h00, v);
        check("R5 R7 applied and cleared", v, 32'h8000_0000);
        check("R5 cfg applied", {act_src, act_div, act_mode}, {22'h0, 3'd1, 5'd7, 2'd2});
        check("R5 mnd applied", act_word(), {16'hFFF9, 8'hF8, 8'h03});
        check("R10 dual edge on", act_mnd_on, 1'b1);
    endtask

    task automatic t_safe_apply();
        logic [31:0] v;
        reg_wr(5'h00, 32'h0000_0002);
        reg_rd(5'h00, v);
        check("R9 root enabled", v, 32'h0000_0002);
        reg_wr(5'h04, 32'h0000_0305);
        reg_wr(5'h08, 32'h0000_0003);
        reg_rd(5'h00, v);
        check("R6 unchanged value keeps M clean", v, 32'h0000_0012);
        reg_wr(5'h00, 32'h0000_0003);
        repeat (5) @(negedge clk);
        reg_rd(5'h00, v);
        check("R4 pending waits for strobe", v, 32'h0000_0013);
        check("R3 R4 active held while waiting", act_src, 3'd1);
        reg_wr(5'h00, 32'h0000_0002);
        reg_rd(5'h00, v);
        check("R8 zero write keeps pending", v, 32'h0000_0013);
        reg_wr(5'h08, 32'h0000_0005);
        reg_rd(5'h00, v);
        check("R7 write while pending flagged", v, 32'h0000_0033);
        safe_sw = 1'b1;
        @(negedge clk);
        safe_sw = 1'b0;
        reg_rd(5'h00, v);
        check("R4 R7 cleared after strobe", v, 32'h0000_0002);
        check("R4 cfg applied", {act_src, act_div, act_mode}, {22'h0, 3'd3, 5'd5, 2'd0});
        check("R7 merged M applied", act_m, 16'h0005);
        check("R10 bypass mode", act_mnd_on, 1'b0);
    endtask

    task automatic t_same_edge();
        logic [31:0] v;
        reg_wr(5'h0C, 32'h0000_0010);
        reg_wr(5'h00, 32'h0000_0003);
        wr_en = 1'b1; wr_addr = 5'h0C; wr_data = 32'h0000_0020; safe_sw = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; safe_sw = 1'b0;
        check("R11 commit takes old N", act_n, 16'h0010);
        reg_rd(5'h0C, v);
        check("R11 new N stays staged", v, 32'h0000_0020);
        reg_rd(5'h00, v);
        check("R11 N dirty kept", v, 32'h0000_0042);
    endtask

    task automatic t_hw_enable();
        logic [31:0] v;
        reg_wr(5'h00, 32'h0000_0000);
        hw_root_en = 1'b1;
        reg_rd(5'h00, v);
        check("R9 hw enable clears off", v, 32'h0000_0040);
        hw_root_en = 1'b0;
        reg_rd(5'h00, v);
        check("R9 both off sets status", v, 32'h8000_0040);
        check("R9 root_off pin", root_off, 1'b1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_map();
        t_root_off_apply();
        t_safe_apply();
        t_same_edge();
        t_hw_enable();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog expired");
            end
        join_any
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule